// File: doc/BRIEF.md
# Telescopic Variable-Latency Adder

This block adds two 64-bit two's-complement operands and returns the 64-bit sum. Most additions in real workloads involve small values, so the unit first looks at the operands. If both of them fit in a signed 16-bit field, the unit produces the result in one cycle with a narrow adder. Otherwise it uses a second cycle: the low 16 bits are summed first and their carry is kept in a register, and the upper 48 bits are summed in the next cycle with that carry added in.

Operands arrive on an elastic channel with valid/stop handshaking, and results leave on another one. A pair of operands is taken when the input valid is high and the input stop is low. A result is handed over when the output valid is high and the downstream stop is low. The unit raises the input stop while a wide addition is still running, and also while an undelivered result is being held back. Because of this handshake, a caller sees the same sequence of sums whether each addition takes one cycle or two.

Top module: `tele_adder`

## Requirements
- R1: An operand is narrow when its bits 63 down to 15 are all equal to bit 15. An addition takes the one-cycle path exactly when both operands are narrow.
- R2: After a narrow pair is taken on a clock edge, out_valid is high in the following cycle. out_sum then holds the 17-bit signed sum of the low 16 bits, sign-extended to 64 bits. This value equals a+b.
- R3: After a pair that is not narrow is taken on a clock edge, out_valid is low in the following cycle. out_valid goes high one cycle later, and out_sum then equals a+b modulo 2^64.
- R4: While a wide addition is in its second cycle, in_stop is high and no new operand pair is taken.
- R5: While out_valid and out_stop are both high, out_valid stays high and out_sum does not change.
- R6: While a result is being held (out_valid and out_stop both high), in_stop is high.
- R7: During reset and right after it, out_valid is low and in_stop is low.
- R8: In a wide addition, the carry out of bit 15 is added into bit 16 of the upper part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand pair is present |
| in_stop | output | 1 | The unit cannot take an operand pair this cycle |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | A result is present |
| out_stop | input | 1 | The downstream side cannot take the result this cycle |
| out_sum | output | 64 | Sum |

## Verification
The operand table mixes several kinds of pairs: two positive narrow values, two negative narrow values, narrow pairs whose 17-bit sum overflows 16 bits, and pairs that sit just past the narrow boundary at bit 15. For each pair, the bench measures the latency against its own narrow/wide classification, which shows whether the classification and the path selection agree. Wide pairs include one whose low halves carry into bit 16, which exposes a lost or misplaced carry. Directed tests hold a second pair at the input during a wide addition and apply downstream stop to a waiting result, which covers both sources of input stop.

// File: rtl/tele_adder.sv
module tele_adder #(
  parameter int W  = 64,
  parameter int SW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_stop,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_stop,
  output logic [W-1:0] out_sum
);
  localparam int HW = W - SW;

  logic          busy;
  logic          cy_q;
  logic [HW-1:0] ahi_q, bhi_q;
  logic          a_short, b_short, is_short, take, out_free;
  logic [SW:0]   short_sum, lo_full;
  logic [HW-1:0] hi_sum;

  assign a_short   = (&in_a[W-1:SW-1]) | ~(|in_a[W-1:SW-1]);
  assign b_short   = (&in_b[W-1:SW-1]) | ~(|in_b[W-1:SW-1]);
  assign is_short  = a_short & b_short;
  assign short_sum = {in_a[SW-1], in_a[SW-1:0]} + {in_b[SW-1], in_b[SW-1:0]};
  assign lo_full   = {1'b0, in_a[SW-1:0]} + {1'b0, in_b[SW-1:0]};
  assign hi_sum    = ahi_q + bhi_q + {{(HW-1){1'b0}}, cy_q};

  assign out_free = ~out_valid | ~out_stop;
  assign in_stop  = busy | ~out_free;
  assign take     = in_valid & ~in_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cy_q      <= 1'b0;
      ahi_q     <= '0;
      bhi_q     <= '0;
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else if (busy) begin
      out_sum[W-1:SW] <= hi_sum;
      out_valid       <= 1'b1;
      busy            <= 1'b0;
    end else if (take) begin
      if (is_short) begin
        out_sum   <= {{(W-SW-1){short_sum[SW]}}, short_sum};
        out_valid <= 1'b1;
      end else begin
        out_sum[SW-1:0] <= lo_full[SW-1:0];
        cy_q            <= lo_full[SW];
        ahi_q           <= in_a[W-1:SW];
        bhi_q           <= in_b[W-1:SW];
        busy            <= 1'b1;
        out_valid       <= 1'b0;
      end
    end else if (out_valid && !out_stop) begin
      out_valid <= 1'b0;
    end
  end

  a_r2_short_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_short) |=> (out_valid && out_sum == $past(in_a) + $past(in_b)));

  a_r3_long_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_short) |=> (!out_valid ##1 (out_valid && out_sum == $past(in_a, 2) + $past(in_b, 2))));

  a_r4_stop_while_long: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_short) |=> in_stop);

  a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_stop) |=> (out_valid && $stable(out_sum)));

  a_r7_reset_idle: assert property (@(posedge clk)
    (!rst_n) |=> (!out_valid && !in_stop));
endmodule

// File: tb/tele_adder_bench.sv
module tele_adder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_stop;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_stop = 1'b0;
  logic [63:0] out_sum;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tele_adder u_tele_adder (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stop(in_stop),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_stop(out_stop), .out_sum(out_sum));

  localparam int NV = 10;
  localparam logic [63:0] VA [NV] = '{
    64'h0000_0000_0000_0005, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_7FFF,
    64'hFFFF_FFFF_FFFF_8000, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_FFFF,
    64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0000_0000_0000_1234,
    64'hFFFF_FFFF_FFFF_FFFF };
  localparam logic [63:0] VB [NV] = '{
    64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFF1, 64'h0000_0000_0000_7FFF,
    64'hFFFF_FFFF_FFFF_8000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001,
    64'h0FED_CBA9_8765_4321, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000,
    64'h0000_0000_0000_0001 };

  function automatic bit narrow(input logic [63:0] v);
    return (v[63:15] == '0) || (v[63:15] == '1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_add(input logic [63:0] a, input logic [63:0] b);
    int lat = 1;
    int want;
    want = (narrow(a) && narrow(b)) ? 1 : 2;
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    if (want == 2) check(in_stop, "R4 stop during long add", 64'(in_stop), 64'd1);
    while (!out_valid && lat < 6) begin @(negedge clk); lat++; end
    check(lat == want, want == 1 ? "R1 R2 short latency" : "R1 R3 long latency", 64'(lat), 64'(want));
    check(out_sum == a + b, want == 1 ? "R2 short sum" : "R3 R8 long sum", out_sum, a + b);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    check(!out_valid && !in_stop, "R7 in reset", {62'd0, out_valid, in_stop}, 64'd0);
    #20 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !in_stop, "R7 after reset", {62'd0, out_valid, in_stop}, 64'd0);

    for (int i = 0; i < NV; i++) run_add(VA[i], VB[i]);

    // R8: low-half carry into bit 16
    run_add(64'h0000_0000_0001_FFFF, 64'h0000_0000_0001_0001);

    // R4: second pair presented during long add is taken only after the result
    @(negedge clk);
    in_a = 64'h0000_1000_0000_0001; in_b = 64'h0000_2000_0000_0002; in_valid = 1'b1;
    @(posedge clk); #1;
    in_a = 64'd7; in_b = 64'd9;
    @(negedge clk);
    check(in_stop && !out_valid, "R4 busy blocks input", {62'd0, in_stop, out_valid}, 64'd2);
    @(negedge clk);
    check(out_valid && out_sum == 64'h0000_3000_0000_0003, "R4 first result", out_sum, 64'h0000_3000_0000_0003);
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_sum == 64'd16, "R4 second pair after", out_sum, 64'd16);

    // R5, R6: hold result under downstream stop
    @(negedge clk);
    out_stop = 1'b1;
    in_a = 64'hFFFF_FFFF_FFFF_FFFE; in_b = 64'd5; in_valid = 1'b1;
    @(posedge clk); #1;
    in_a = 64'd100; in_b = 64'd200;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid && out_sum == 64'd3, "R5 held result", out_sum, 64'd3);
      check(in_stop, "R6 input stopped", 64'(in_stop), 64'd1);
    end
    out_stop = 1'b0;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_sum == 64'd300, "R6 pair taken after release", out_sum, 64'd300);
    @(negedge clk);
    check(!out_valid, "R5 result consumed", 64'(out_valid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule